// File: doc/BRIEF.md
# Configurable SPI Byte Transceiver

This block moves one byte at a time over an SPI link and can act either as the link's master or as a selected slave. An 8-bit control register picks the role, the clock polarity and phase, the bit order, the clock source and a rate divider. A host writes a byte into the data port. As master, the block starts a transfer at once. As slave, it waits for the remote master to select it and clock the byte out. When the eighth bit is captured, the received byte appears on `rx_data` and `done` pulses for one clock.

In master mode the serial clock comes from a counter. This counter advances either on every system clock or on each pulse of an external timer-overflow strobe, and it toggles the serial clock after half of the selected ratio. In slave mode the incoming serial clock, select and data pass through two-stage synchronisers. The block then runs in the system clock domain and finds the serial clock edges there. Output-enable lines for the serial clock, MOSI and MISO let the pads release the lines whenever the block must not drive them.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control register reads 0x00, `done` is low, `sck_o` is low and all three output enables are low.
- R2: The control byte is decoded as follows: bit 7 clock source, bit 6 enable, bit 5 bit order, bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate. A written value reads back unchanged on `ctrl_o`.
- R3: In master mode each half period of the serial clock lasts ratio/2 base ticks. The ratio is 4, 16, 64 or 128 for rate code 0, 1, 2 or 3. A base tick is every system clock when the clock-source bit is 0, and every `tmr_ovf` pulse when it is 1.
- R4: With the bit-order bit at 1 the least significant bit travels first; at 0 the most significant bit travels first. This holds in both directions.
- R5: While the master is idle, `sck_o` equals the clock-polarity bit.
- R6: With phase 0, the first bit is valid before the first edge, the leading edge samples and the trailing edge launches. With phase 1, the leading edge launches and the trailing edge samples. A leading edge moves the clock away from its idle level.
- R7: A data write while the master is idle starts an 8-bit transfer. A data write during a transfer is ignored. At the end, `rx_data` holds the received byte and `done` is high for exactly one cycle.
- R8: When the block is enabled as master, `sck_oe` is high, `mosi_oe` is high only during a transfer, and `miso_oe` is low.
- R9: `miso_oe` is high only when the block is enabled as slave, `ss_n_i` is low and `slv_out_dis` is low. As slave, `sck_oe` and `mosi_oe` stay low.
- R10: With the enable bit at 0, all output enables are low and a data write starts no transfer and produces no `done`.
- R11: As slave, after eight sample edges while selected, the byte shifted in from `mosi_i` is latched on `rx_data` and `done` pulses. The preloaded byte is shifted out on `miso_o`. The system clock must run at least four times the serial clock rate.
- R12: If the select line rises in the middle of a slave transfer, the partial byte is dropped without a `done`. The next full transfer then delivers the correct bytes in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| data_we | input | 1 | Data write strobe (start in master, preload in slave) |
| data_wdata | input | 8 | Byte to transmit |
| tmr_ovf | input | 1 | Timer overflow strobe, alternative base tick |
| slv_out_dis | input | 1 | Forces MISO release in slave mode |
| sck_i | input | 1 | Serial clock from the remote master |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in (slave mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| ctrl_o | output | 8 | Current control register |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Master transfer in progress |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | MISO output enable |

## Verification
The bench runs the master through every polarity, phase, bit order and rate, with asymmetric bytes, and measures the spacing of every serial clock edge. A wrong divider or a timer strobe taken as the wrong source therefore shows up as a mismatched gap. A reversed order or a launch on the wrong edge shows up as a scrambled byte on MOSI or in `rx_data`. A second data write is issued during each transfer, so a design that restarted would emit an extra or corrupted byte, or pulse `done` twice. As slave, the bench drives all four modes, raises select partway through a byte and checks the next transfer. It also toggles the output-disable and enable bits, so a counter that kept stale bits would misalign every later byte, and an enable that ignored the select line or the enable bit would leave MISO driven.

// File: rtl/spi_xcvr_pkg.sv
// Shared types for the SPI byte transceiver.
// Assumes: the control byte layout below is fixed by software and must not move.
package spi_xcvr_pkg;

    // Control register fields, most significant bit first.
    typedef struct packed {
        logic       clk_src;    // 0: system clock base, 1: timer strobe base
        logic       enable;
        logic       lsb_first;
        logic       is_master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } spi_ctrl_t;

endpackage

// File: rtl/spi_edge_gen.sv
// Serial clock edge generator for master mode.
// Emits a one-cycle tick each time the serial clock must toggle, which is
// every ratio/2 base ticks. A base tick is either every system clock or a
// timer overflow pulse. The counter is held at zero while not running so
// every transfer starts from a full half period.
// Assumes: ratios are even and RATIO3 is the largest one.
module spi_edge_gen #(
    parameter int RATIO0 = 4,
    parameter int RATIO1 = 16,
    parameter int RATIO2 = 64,
    parameter int RATIO3 = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clk_src,
    input  logic       tmr_ovf,
    input  logic [1:0] rate,
    output logic       edge_tick
);
    localparam int HMAX = RATIO3 / 2;
    localparam int HW   = $clog2(HMAX + 1);

    logic [HW-1:0] half_m1;
    logic [HW-1:0] cnt;
    logic          base;

    // Select the half-period terminal count for the chosen rate.
    always_comb begin
        case (rate)
            2'd0:    half_m1 = HW'(RATIO0 / 2 - 1);
            2'd1:    half_m1 = HW'(RATIO1 / 2 - 1);
            2'd2:    half_m1 = HW'(RATIO2 / 2 - 1);
            default: half_m1 = HW'(RATIO3 / 2 - 1);
        endcase
    end

    assign base      = clk_src ? tmr_ovf : 1'b1;
    assign edge_tick = run & base & (cnt == half_m1);

    // Count base ticks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (base) begin
            if (cnt == half_m1) cnt <= '0;
            else                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_master_eng.sv
// Master shift engine: runs one DW-bit transfer per start pulse.
// Every edge tick toggles the clock level. Edges are numbered from zero.
// Even edges are leading edges. Sample edges are those whose parity equals
// the clock phase. The remaining edges launch the next bit, except edge 0,
// whose bit is already on the line.
// Assumes: start only arrives while idle; enable low aborts silently.
module spi_master_eng #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    input  logic          lsb_first,
    input  logic          cpha,
    input  logic          edge_tick,
    input  logic          miso_in,
    output logic          busy,
    output logic          sck_lvl,
    output logic          mosi_bit,
    output logic [DW-1:0] rx_byte,
    output logic          done
);
    localparam int NEDGE = 2 * DW;
    localparam int EW    = $clog2(NEDGE);

    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;
    logic [DW-1:0] rx_next;
    logic [DW-1:0] tx_next;
    logic [EW-1:0] ecnt;
    logic          sample_edge;
    logic          last_edge;

    assign sample_edge = (ecnt[0] == cpha);
    assign last_edge   = (ecnt == EW'(NEDGE - 1));
    assign mosi_bit    = lsb_first ? tx_sr[0] : tx_sr[DW-1];

    // Form the receive and transmit shift results for the configured order.
    always_comb begin
        if (lsb_first) begin
            rx_next = {miso_in, rx_sr[DW-1:1]};
            tx_next = {1'b0, tx_sr[DW-1:1]};
        end else begin
            rx_next = {rx_sr[DW-2:0], miso_in};
            tx_next = {tx_sr[DW-2:0], 1'b0};
        end
    end

    // Transfer sequencing, clock level and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sck_lvl <= 1'b0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            ecnt    <= '0;
            rx_byte <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                busy    <= 1'b0;
                sck_lvl <= 1'b0;
                ecnt    <= '0;
            end else if (start) begin
                busy    <= 1'b1;
                sck_lvl <= 1'b0;
                tx_sr   <= tx_byte;
                rx_sr   <= '0;
                ecnt    <= '0;
            end else if (busy && edge_tick) begin
                sck_lvl <= ~sck_lvl;
                if (sample_edge)            rx_sr <= rx_next;
                if (!sample_edge && ecnt != '0) tx_sr <= tx_next;
                if (last_edge) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    rx_byte <= sample_edge ? rx_next : rx_sr;
                    ecnt    <= '0;
                end else begin
                    ecnt <= ecnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_slave_eng.sv
// Slave shift engine driven by an external serial clock.
// The serial clock, select and data inputs pass through SYNC-stage
// synchronisers, and edges are found in the system clock domain. While
// deselected, the bit counter and receive register are cleared and the
// transmit register follows the preload buffer, so a select that drops
// mid-byte leaves nothing behind.
// Assumes: the system clock runs at least four times the serial clock.
module spi_slave_eng #(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sck_in,
    input  logic          ss_n_in,
    input  logic          mosi_in,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          tx_we,
    input  logic [DW-1:0] tx_byte,
    output logic          miso_bit,
    output logic [DW-1:0] rx_byte,
    output logic          done
);
    localparam int BCW = $clog2(DW);

    logic [SYNC-1:0] sck_sy;
    logic [SYNC-1:0] ss_sy;
    logic [SYNC-1:0] mosi_sy;
    logic            sck_d;
    logic            sel;
    logic            lvl_now;
    logic            lvl_old;
    logic            lead;
    logic            trail;
    logic            smp;
    logic            lch;
    logic [DW-1:0]   tx_buf;
    logic [DW-1:0]   tx_sr;
    logic [DW-1:0]   rx_sr;
    logic [DW-1:0]   rx_next;
    logic [DW-1:0]   tx_next;
    logic [DW-1:0]   reload;
    logic [BCW-1:0]  bcnt;

    // Bring the external pins into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy  <= '0;
            ss_sy   <= '1;
            mosi_sy <= '0;
            sck_d   <= 1'b0;
        end else begin
            sck_sy  <= {sck_sy[SYNC-2:0], sck_in};
            ss_sy   <= {ss_sy[SYNC-2:0], ss_n_in};
            mosi_sy <= {mosi_sy[SYNC-2:0], mosi_in};
            sck_d   <= sck_sy[SYNC-1];
        end
    end

    assign sel     = enable & ~ss_sy[SYNC-1];
    assign lvl_now = sck_sy[SYNC-1] ^ cpol;
    assign lvl_old = sck_d ^ cpol;
    assign lead    = sel & lvl_now & ~lvl_old;
    assign trail   = sel & ~lvl_now & lvl_old;
    assign smp     = cpha ? trail : lead;
    assign lch     = cpha ? lead : trail;
    assign miso_bit = lsb_first ? tx_sr[0] : tx_sr[DW-1];
    assign reload  = tx_we ? tx_byte : tx_buf;

    // Form the receive and transmit shift results for the configured order.
    always_comb begin
        if (lsb_first) begin
            rx_next = {mosi_sy[SYNC-1], rx_sr[DW-1:1]};
            tx_next = {1'b0, tx_sr[DW-1:1]};
        end else begin
            rx_next = {rx_sr[DW-2:0], mosi_sy[SYNC-1]};
            tx_next = {tx_sr[DW-2:0], 1'b0};
        end
    end

    // Hold the most recent preload byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_buf <= '0;
        else if (tx_we) tx_buf <= tx_byte;
    end

    // Bit counting, shifting and end-of-byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bcnt    <= '0;
            rx_byte <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!sel) begin
                bcnt  <= '0;
                rx_sr <= '0;
                tx_sr <= reload;
            end else if (smp) begin
                if (bcnt == BCW'(DW - 1)) begin
                    done    <= 1'b1;
                    rx_byte <= rx_next;
                    rx_sr   <= '0;
                    bcnt    <= '0;
                    tx_sr   <= reload;
                end else begin
                    rx_sr <= rx_next;
                    bcnt  <= bcnt + 1'b1;
                end
            end else if (lch && bcnt != '0) begin
                tx_sr <= tx_next;
            end
        end
    end
endmodule

// File: rtl/spi_xcvr.sv
// SPI byte transceiver top level.
// Holds the control register, steers data writes to the master or slave
// engine, merges their results and derives the pad output enables.
// Assumes: control changes happen only between transfers.
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SYNC   = 2,
    parameter int RATIO0 = 4,
    parameter int RATIO1 = 16,
    parameter int RATIO2 = 64,
    parameter int RATIO3 = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    input  logic          data_we,
    input  logic [DW-1:0] data_wdata,
    input  logic          tmr_ovf,
    input  logic          slv_out_dis,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          mosi_i,
    input  logic          miso_i,
    output logic [7:0]    ctrl_o,
    output logic [DW-1:0] rx_data,
    output logic          done,
    output logic          busy,
    output logic          sck_o,
    output logic          sck_oe,
    output logic          mosi_o,
    output logic          mosi_oe,
    output logic          miso_o,
    output logic          miso_oe
);
    spi_ctrl_t     ctrl_q;
    logic          m_en;
    logic          s_en;
    logic          m_start;
    logic          m_busy;
    logic          m_lvl;
    logic          m_done;
    logic          s_done;
    logic          edge_tick;
    logic [DW-1:0] m_rx;
    logic [DW-1:0] s_rx;
    logic [DW-1:0] rx_q;

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= spi_ctrl_t'(ctrl_wdata);
    end

    assign m_en    = ctrl_q.enable & ctrl_q.is_master;
    assign s_en    = ctrl_q.enable & ~ctrl_q.is_master;
    assign m_start = data_we & m_en & ~m_busy;

    spi_edge_gen #(
        .RATIO0 (RATIO0),
        .RATIO1 (RATIO1),
        .RATIO2 (RATIO2),
        .RATIO3 (RATIO3)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (m_busy),
        .clk_src   (ctrl_q.clk_src),
        .tmr_ovf   (tmr_ovf),
        .rate      (ctrl_q.rate),
        .edge_tick (edge_tick)
    );

    spi_master_eng #(.DW(DW)) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (m_en),
        .start     (m_start),
        .tx_byte   (data_wdata),
        .lsb_first (ctrl_q.lsb_first),
        .cpha      (ctrl_q.cpha),
        .edge_tick (edge_tick),
        .miso_in   (miso_i),
        .busy      (m_busy),
        .sck_lvl   (m_lvl),
        .mosi_bit  (mosi_o),
        .rx_byte   (m_rx),
        .done      (m_done)
    );

    spi_slave_eng #(.DW(DW), .SYNC(SYNC)) u_slv (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (s_en),
        .sck_in    (sck_i),
        .ss_n_in   (ss_n_i),
        .mosi_in   (mosi_i),
        .cpol      (ctrl_q.cpol),
        .cpha      (ctrl_q.cpha),
        .lsb_first (ctrl_q.lsb_first),
        .tx_we     (data_we & ~ctrl_q.is_master),
        .tx_byte   (data_wdata),
        .miso_bit  (miso_o),
        .rx_byte   (s_rx),
        .done      (s_done)
    );

    // Latch whichever engine finished last.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_q <= '0;
        else if (m_done) rx_q <= m_rx;
        else if (s_done) rx_q <= s_rx;
    end

    assign ctrl_o  = ctrl_q;
    assign rx_data = rx_q;
    assign done    = m_done | s_done;
    assign busy    = m_busy;
    assign sck_o   = ctrl_q.cpol ^ m_lvl;
    assign sck_oe  = m_en;
    assign mosi_oe = m_en & m_busy;
    assign miso_oe = s_en & ~ss_n_i & ~slv_out_dis;
endmodule

// File: rtl/spi_xcvr_chk.sv
// Protocol checker for spi_xcvr, attached through bind.
// Assumes: reset is synchronous and active low.
module spi_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_we,
    input logic       ss_n_i,
    input logic       slv_out_dis,
    input logic [7:0] ctrl_o,
    input logic       busy,
    input logic       done,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe
);
    // R8
    mst_idle_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[6] && ctrl_o[4] && !busy) |-> !mosi_oe);

    // R5
    sck_idle_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[6] && ctrl_o[4] && !busy) |-> (sck_o == ctrl_o[3]));

    // R9
    miso_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (!ss_n_i && !slv_out_dis && !ctrl_o[4] && ctrl_o[6]));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[6] |-> !(sck_oe || mosi_oe || miso_oe || busy));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(data_we));
endmodule

bind spi_xcvr spi_xcvr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_we     (data_we),
    .ss_n_i      (ss_n_i),
    .slv_out_dis (slv_out_dis),
    .ctrl_o      (ctrl_o),
    .busy        (busy),
    .done        (done),
    .sck_o       (sck_o),
    .sck_oe      (sck_oe),
    .mosi_oe     (mosi_oe),
    .miso_oe     (miso_oe)
);

// File: tb/sim_spi_xcvr.sv
`timescale 1ns/1ps
module sim_spi_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       tmr_ovf = 1'b0;
    logic       slv_out_dis = 1'b0;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       mosi_i = 1'b0;
    logic       miso_i = 1'b0;
    logic [7:0] ctrl_o;
    logic [7:0] rx_data;
    logic       done, busy, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    spi_xcvr u0 (.*);

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0;
    int n_err = 0;

    // Timer strobe: one pulse every 3 system clocks.
    int tcnt = 0;
    always @(negedge clk) begin
        tcnt    = (tcnt + 1) % 3;
        tmr_ovf = (tcnt == 0);
    end

    // Count done pulses away from the active edge.
    int done_cnt = 0;
    always @(negedge clk) if (done) done_cnt++;

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog R7 act=%0d exp=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err + 1);
            $finish;
        end
    end

    // Master-side monitor and model slave; settings come from the task.
    int         req_id = 0;
    logic       m_cpol = 0, m_cpha = 0, m_dord = 0;
    logic [7:0] s_byte = '0;
    int         exp_gap = 0;
    int         last_id = 0;
    int         idx = 0, sl_idx = 0, gap = 0, gap_bad = 0;
    logic       seen = 0, prev_sck = 0;
    logic [7:0] mon_byte = '0;
    always @(negedge clk) begin
        if (req_id != last_id) begin
            last_id = req_id;
            idx = 0; gap = 0; gap_bad = 0; seen = 0; mon_byte = '0;
            if (!m_cpha) begin
                miso_i = m_dord ? s_byte[0] : s_byte[7];
                sl_idx = 1;
            end else begin
                sl_idx = 0;
            end
        end else begin
            gap++;
            if (sck_o != prev_sck) begin
                if (seen && gap != exp_gap) gap_bad++;
                seen = 1; gap = 0;
                if ((sck_o != m_cpol) ^ m_cpha) begin
                    if (idx < 8) mon_byte[m_dord ? idx : 7 - idx] = mosi_o;
                    idx++;
                end else if (sl_idx < 8) begin
                    miso_i = m_dord ? s_byte[sl_idx] : s_byte[7 - sl_idx];
                    sl_idx++;
                end
            end
        end
        prev_sck = sck_o;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_we = 1'b1; data_wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask

    function automatic int ratio_of(input int r);
        return (r == 0) ? 4 : (r == 1) ? 16 : (r == 2) ? 64 : 128;
    endfunction

    // One master transfer with the model slave returning s.
    task automatic mst_xfer(input logic cpol, input logic cpha, input logic dord,
                            input int rate, input logic csel,
                            input logic [7:0] m, input logic [7:0] s);
        int d0;
        wr_ctrl({csel, 1'b1, dord, 1'b1, cpol, cpha, 2'(rate)});
        check("R5 idle sck", sck_o, cpol);
        check("R8 sck_oe", sck_oe, 1);
        m_cpol = cpol; m_cpha = cpha; m_dord = dord; s_byte = s;
        exp_gap = (ratio_of(rate) / 2) * (csel ? 3 : 1);
        req_id++;
        @(negedge clk);
        d0 = done_cnt;
        wr_data(m);
        wr_data(~m);            // ignored while busy
        check("R8 mosi_oe busy", mosi_oe, 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        check("R4 R6 mosi byte", mon_byte, m);
        check("R6 R7 rx byte", rx_data, s);
        check("R3 edge gap", gap_bad, 0);
        check("R7 single done", done_cnt - d0, 1);
        check("R5 sck after", sck_o, cpol);
        check("R8 mosi_oe idle", mosi_oe, 0);
    endtask

    localparam int HP = 8;

    task automatic clk_bits(input logic cpol, input logic cpha, input logic dord,
                            input logic [7:0] m, input int nb, output logic [7:0] got);
        got = '0;
        for (int k = 0; k < nb; k++) begin
            int p;
            p = dord ? k : 7 - k;
            if (!cpha) begin
                mosi_i = m[p];
                repeat (HP) @(negedge clk);
                got[p] = miso_o;
                sck_i = ~cpol;
                repeat (HP) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol;
                mosi_i = m[p];
                repeat (HP) @(negedge clk);
                got[p] = miso_o;
                sck_i = cpol;
                repeat (HP) @(negedge clk);
            end
        end
        repeat (HP) @(negedge clk);
    endtask

    // One slave transfer; abort_bits > 0 first sends a cut-short byte.
    task automatic slv_xfer(input logic cpol, input logic cpha, input logic dord,
                            input logic [7:0] m, input logic [7:0] s, input int abort_bits);
        int d0;
        logic [7:0] got;
        sck_i = cpol; ss_n_i = 1'b1;
        wr_ctrl({1'b0, 1'b1, dord, 1'b0, cpol, cpha, 2'b00});
        wr_data(s);
        repeat (4) @(negedge clk);
        check("R9 miso_oe deselected", miso_oe, 0);
        check("R9 sck/mosi oe slave", {sck_oe, mosi_oe}, 0);
        if (abort_bits > 0) begin
            d0 = done_cnt;
            ss_n_i = 1'b0;
            repeat (HP) @(negedge clk);
            clk_bits(cpol, cpha, dord, 8'hC3, abort_bits, got);
            ss_n_i = 1'b1;
            repeat (HP) @(negedge clk);
            check("R12 no done on abort", done_cnt - d0, 0);
        end
        d0 = done_cnt;
        ss_n_i = 1'b0;
        repeat (HP) @(negedge clk);
        check("R9 miso_oe selected", miso_oe, 1);
        clk_bits(cpol, cpha, dord, m, 8, got);
        check(abort_bits > 0 ? "R12 rx after abort" : "R11 R4 slave rx", rx_data, m);
        check(abort_bits > 0 ? "R12 tx after abort" : "R11 R6 slave tx", got, s);
        check("R11 slave done", done_cnt - d0, 1);
        ss_n_i = 1'b1;
        @(negedge clk);
        check("R9 miso_oe released", miso_oe, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl reset", ctrl_o, 8'h00);
        check("R1 oe reset", {sck_oe, mosi_oe, miso_oe}, 0);
        check("R1 done/sck reset", {done, sck_o}, 0);
        // R2 register layout readback
        wr_ctrl(8'hA5);
        check("R2 ctrl readback", ctrl_o, 8'hA5);
        // R10 disabled: master select set but enable clear
        begin
            int d0;
            wr_ctrl(8'h1C);
            d0 = done_cnt;
            wr_data(8'h5A);
            repeat (600) @(negedge clk);
            check("R10 no done when off", done_cnt - d0, 0);
            check("R10 oe off", {sck_oe, mosi_oe, miso_oe, busy}, 0);
            ss_n_i = 1'b0;
            @(negedge clk);
            check("R10 miso_oe off", miso_oe, 0);
            ss_n_i = 1'b1;
        end
        // Master sweep over modes, order, rate
        for (int mode = 0; mode < 8; mode++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] mb, sb;
                mb = 8'h81 ^ 8'(mode * 37 + r * 11);
                sb = {mb[3:0], ~mb[7:4]} ^ 8'h2C;
                mst_xfer(mode[2], mode[1], mode[0], r, 1'b0, mb, sb);
                mst_xfer(mode[2], mode[1], mode[0], r, 1'b0, 8'h01 << mode, 8'h80 >> r);
            end
        end
        // Timer-strobe clock source (R3)
        for (int k = 0; k < 4; k++)
            mst_xfer(k[0], k[1], k[0], k / 2, 1'b1, 8'hB4 ^ 8'(k), 8'h1E ^ 8'(k * 3));
        // Slave sweep
        for (int mode = 0; mode < 8; mode++) begin
            slv_xfer(mode[2], mode[1], mode[0], 8'hC6 ^ 8'(mode * 9), 8'h39 ^ 8'(mode * 5), 0);
            slv_xfer(mode[2], mode[1], mode[0], 8'h01, 8'h80, 0);
        end
        // SS abort mid-byte (R12)
        slv_xfer(1'b0, 1'b0, 1'b0, 8'hA7, 8'h4D, 3);
        slv_xfer(1'b1, 1'b1, 1'b1, 8'h2B, 8'hD2, 5);
        // Slave output disable (R9)
        wr_ctrl(8'h40);
        slv_out_dis = 1'b1; ss_n_i = 1'b0;
        @(negedge clk);
        check("R9 miso_oe disabled", miso_oe, 0);
        slv_out_dis = 1'b0;
        @(negedge clk);
        check("R9 miso_oe re-enabled", miso_oe, 1);
        ss_n_i = 1'b1;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule